// File: doc/BRIEF.md
# Address-Window Counting Semaphore Bank

This block is a bank of hardware counting semaphores on a memory-mapped bus. Every semaphore can be reached at four aliased addresses, one in each of four windows. The window an access lands in, not the data or any command field, selects what happens. The four operations are a plain read, a load with the write data, an add of one, and a subtract of one. A DMA engine can point a descriptor tail write at the add-one window, so that each landed write counts as an arrival or doorbell event.

A local sequencer port can add or subtract one on any semaphore in the same cycle as a bus access. When both touch one semaphore, their net effect is applied together in a single cycle. A set of wait comparators compares chosen semaphores against targets and raises a greater-or-equal status, so a waiter needs no bus polling. Counters saturate at both ends, and two sticky flags record any clamp.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore reads 0, `rsp_valid` is 0, and both `ovf_flag` and `unf_flag` are 0.
- R2: Word offsets select the operation by window: 0x1000–0x13FC reads, 0x1400–0x17FC sets, 0x1800–0x1BFC adds one, 0x1C00–0x1FFC subtracts one. The semaphore index is (offset − window base) / 4. A write in the set window loads `bus_wdata` into that semaphore.
- R3: A write in the add-one window raises the semaphore by exactly one, and a write in the subtract-one window lowers it by exactly one. In both cases `bus_wdata` is ignored.
- R4: A read in any of the four windows returns the semaphore's value in `rsp_rdata` one cycle later and changes nothing. A write in the read window has no effect. Every write response carries `rsp_rdata` = 0.
- R5: Every bus access gets exactly one response, with `rsp_valid` high in the next cycle. An access outside the four windows, with `bus_addr[1:0]` ≠ 0, or with an index ≥ NUM_SEM returns `rsp_err` = 1 and `rsp_rdata` = 0 and changes no semaphore.
- R6: An add at the all-ones value leaves it at all-ones and sets `ovf_flag`. A subtract at 0 leaves it at 0 and sets `unf_flag`. Both flags stay set until reset.
- R7: The local port (`loc_dec` = 1 subtracts, 0 adds) changes `loc_idx` by one. When it hits the same semaphore as a bus add or subtract in the same cycle, the summed change is applied once. An add and a subtract therefore cancel with no flag, even at all-ones or 0.
- R8: When a bus set and a local operation target the same semaphore in the same cycle, the set value is stored and the local operation is dropped.
- R9: `wait_ge[k]` is 1 when the value of semaphore `wait_idx[k]` is ≥ `wait_target[k]`, compared as unsigned. With REG_WAIT = 1 the output is registered and reflects the state one cycle earlier.
- R10: A bus operation and a local operation on different semaphores both take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | WIDTH | Write data (used by the set window only) |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | WIDTH | Read value, 0 on writes and errors |
| rsp_err | output | 1 | Decode error for the previous access |
| loc_valid | input | 1 | Local operation present |
| loc_dec | input | 1 | 1 = subtract one, 0 = add one |
| loc_idx | input | IDX_W | Semaphore targeted by the local port |
| wait_idx | input | NUM_WAIT*IDX_W | Packed semaphore index per comparator |
| wait_target | input | NUM_WAIT*WIDTH | Packed threshold per comparator |
| wait_ge | output | NUM_WAIT | Greater-or-equal status per comparator |
| ovf_flag | output | 1 | Sticky: an add was clamped at all-ones |
| unf_flag | output | 1 | Sticky: a subtract was clamped at 0 |

## Verification
The bench sweeps every index through all four windows. A decoder that swapped windows or mis-scaled the index would therefore corrupt a neighbour or a different operation, and the read-back would expose it. It also hits the same semaphore from both ports in one cycle. A design that serialised the two changes, or let the local operation override a bus set, would leave a value one off. At all-ones and 0, a cancelling add and subtract must not clamp or raise a flag; a design that applies them one after the other would. Misaligned and out-of-window addresses must answer with an error and leave the aliased semaphore untouched.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

   // operation selected by the address window
   typedef enum logic [2:0] {
      SOP_NONE,
      SOP_READ,
      SOP_SET,
      SOP_INC,
      SOP_DEC
   } sem_op_e;

   // window layout: bits [11:10] of the offset pick the window inside 0x1000-0x1FFF
   localparam int WIN_REGION   = 1;    // offset >> 12 value of the windowed region
   localparam int WIN_SEL_LSB  = 10;
   localparam int WORD_LSB     = 2;
   localparam int WORD_BITS    = 8;
   localparam int MAX_SEM      = 256;

endpackage

// File: rtl/sem_addr_decode.sv
module sem_addr_decode
   import sem_bank_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int NUM_SEM = 256,
   parameter int IDX_W   = 8
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output sem_op_e           op,
   output logic [IDX_W-1:0]  idx,
   output logic              err
);

   logic                 in_region;
   logic                 aligned;
   logic                 idx_ok;
   logic [1:0]           win;
   logic [WORD_BITS-1:0] word;

   always_comb begin
      in_region = (addr >> 12) == ADDR_W'(WIN_REGION);
      aligned   = addr[1:0] == 2'b00;
      win       = addr[WIN_SEL_LSB+1:WIN_SEL_LSB];
      word      = addr[WORD_LSB+WORD_BITS-1:WORD_LSB];
      idx_ok    = 32'(word) < NUM_SEM;
      idx       = word[IDX_W-1:0];
      err       = valid && !(in_region && aligned && idx_ok);
      op        = SOP_NONE;
      if (valid && !err) begin
         if (!write) begin
            op = SOP_READ;
         end else begin
            unique case (win)
               2'd0:    op = SOP_NONE;   // writes to the read window are dropped
               2'd1:    op = SOP_SET;
               2'd2:    op = SOP_INC;
               default: op = SOP_DEC;
            endcase
         end
      end
   end

endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [WIDTH-1:0] set_val,
   input  logic             inc_a,
   input  logic             inc_b,
   input  logic             dec_a,
   input  logic             dec_b,
   output logic [WIDTH-1:0] value,
   output logic             sat_hi,
   output logic             sat_lo
);

   localparam int EW = WIDTH + 2;
   localparam logic [EW-1:0] CEIL = EW'({WIDTH{1'b1}});

   logic [EW-1:0]    up;
   logic [EW-1:0]    dn;
   logic [EW-1:0]    diff;
   logic [WIDTH-1:0] nxt;

   always_comb begin
      up     = EW'(value) + EW'(inc_a) + EW'(inc_b);
      dn     = EW'(dec_a) + EW'(dec_b);
      diff   = up - dn;
      sat_hi = 1'b0;
      sat_lo = 1'b0;
      if (set_en) begin
         nxt = set_val;
      end else if (up < dn) begin
         nxt    = '0;
         sat_lo = 1'b1;
      end else if (diff > CEIL) begin
         nxt    = '1;
         sat_hi = 1'b1;
      end else begin
         nxt = diff[WIDTH-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= nxt;
   end

endmodule

// File: rtl/sem_wait_cmp.sv
module sem_wait_cmp #(
   parameter int WIDTH   = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_ok,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] target,
   output logic             ge
);

   logic hit;

   assign hit = sel_ok && (cur >= target);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ge <= 1'b0;
            else        ge <= hit;
         end
      end else begin : g_comb
         assign ge = hit;
      end
   endgenerate

endmodule

// File: rtl/sem_bank.sv
module sem_bank
   import sem_bank_pkg::*;
#(
   parameter int  NUM_SEM  = 256,
   parameter int  WIDTH    = 32,
   parameter int  ADDR_W   = 16,
   parameter int  NUM_WAIT = 2,
   parameter bit  REG_WAIT = 1'b1,
   localparam int IDX_W    = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_valid,
   input  logic                      bus_write,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [WIDTH-1:0]          bus_wdata,
   output logic                      rsp_valid,
   output logic [WIDTH-1:0]          rsp_rdata,
   output logic                      rsp_err,
   input  logic                      loc_valid,
   input  logic                      loc_dec,
   input  logic [IDX_W-1:0]          loc_idx,
   input  logic [NUM_WAIT*IDX_W-1:0] wait_idx,
   input  logic [NUM_WAIT*WIDTH-1:0] wait_target,
   output logic [NUM_WAIT-1:0]       wait_ge,
   output logic                      ovf_flag,
   output logic                      unf_flag
);

   generate
      if (NUM_SEM < 1 || NUM_SEM > MAX_SEM) begin : g_bad_num
         $error("NUM_SEM must lie in 1..256");
      end
      if (ADDR_W < 13) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x1FFC");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("WIDTH must be at least 2");
      end
      if (NUM_WAIT < 1) begin : g_bad_wait
         $error("NUM_WAIT must be at least 1");
      end
   endgenerate

   sem_op_e          op;
   logic [IDX_W-1:0] op_idx;
   logic             op_err;

   sem_addr_decode #(
      .ADDR_W (ADDR_W),
      .NUM_SEM(NUM_SEM),
      .IDX_W  (IDX_W)
   ) dec_i (
      .valid(bus_valid),
      .write(bus_write),
      .addr (bus_addr),
      .op   (op),
      .idx  (op_idx),
      .err  (op_err)
   );

   logic [WIDTH-1:0]   vals [NUM_SEM];
   logic [NUM_SEM-1:0] hi_vec;
   logic [NUM_SEM-1:0] lo_vec;

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
         logic bus_hit;
         logic loc_hit;
         assign bus_hit = (op_idx == IDX_W'(g));
         assign loc_hit = loc_valid && (loc_idx == IDX_W'(g));

         sem_cell #(.WIDTH(WIDTH)) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (bus_hit && op == SOP_SET),
            .set_val(bus_wdata),
            .inc_a  (bus_hit && op == SOP_INC),
            .inc_b  (loc_hit && !loc_dec),
            .dec_a  (bus_hit && op == SOP_DEC),
            .dec_b  (loc_hit && loc_dec),
            .value  (vals[g]),
            .sat_hi (hi_vec[g]),
            .sat_lo (lo_vec[g])
         );
      end
   endgenerate

   // bus response, one cycle after the access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= bus_valid;
         rsp_err   <= op_err;
         rsp_rdata <= (op == SOP_READ) ? vals[op_idx] : '0;
      end
   end

   // sticky saturation record
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         unf_flag <= 1'b0;
      end else begin
         ovf_flag <= ovf_flag | (|hi_vec);
         unf_flag <= unf_flag | (|lo_vec);
      end
   end

   generate
      for (genvar k = 0; k < NUM_WAIT; k++) begin : g_wait
         logic [IDX_W-1:0] sel;
         logic             sel_ok;
         logic [WIDTH-1:0] cur;
         assign sel    = wait_idx[k*IDX_W +: IDX_W];
         assign sel_ok = 32'(sel) < NUM_SEM;
         assign cur    = sel_ok ? vals[sel] : '0;

         sem_wait_cmp #(
            .WIDTH  (WIDTH),
            .REG_OUT(REG_WAIT)
         ) cmp_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_ok(sel_ok),
            .cur   (cur),
            .target(wait_target[k*WIDTH +: WIDTH]),
            .ge    (wait_ge[k])
         );
      end
   endgenerate

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
   parameter int ADDR_W  = 16,
   parameter int WIDTH   = 32,
   parameter int NUM_SEM = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [WIDTH-1:0]  rsp_rdata,
   input logic              ovf_flag,
   input logic              unf_flag
);

   logic good_addr;
   assign good_addr = (bus_addr >= ADDR_W'('h1000)) && (bus_addr <= ADDR_W'('h1FFF))
                      && (bus_addr[1:0] == 2'b00)
                      && (32'(bus_addr[9:2]) < NUM_SEM);

   // R5
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> rsp_valid);

   // R5
   no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !rsp_valid);

   // R5
   low_addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr < ADDR_W'('h1000)) |=> (rsp_err && rsp_rdata == '0));

   // R2
   window_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && good_addr) |=> !rsp_err);

   // R4
   write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write) |=> rsp_rdata == '0);

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   // R6
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_flag |=> unf_flag);

endmodule

bind sem_bank sem_bank_chk #(
   .ADDR_W (ADDR_W),
   .WIDTH  (WIDTH),
   .NUM_SEM(NUM_SEM)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_valid(bus_valid),
   .bus_write(bus_write),
   .bus_addr (bus_addr),
   .rsp_valid(rsp_valid),
   .rsp_err  (rsp_err),
   .rsp_rdata(rsp_rdata),
   .ovf_flag (ovf_flag),
   .unf_flag (unf_flag)
);

// File: tb/sem_bank_tb_top.sv
module sem_bank_tb_top;

   localparam int NS = 256;
   localparam int W  = 32;
   localparam int AW = 16;
   localparam int IW = 8;
   localparam int NW = 2;

   localparam logic [AW-1:0] A_RD  = 16'h1000;
   localparam logic [AW-1:0] A_SET = 16'h1400;
   localparam logic [AW-1:0] A_INC = 16'h1800;
   localparam logic [AW-1:0] A_DEC = 16'h1C00;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic             bus_valid, bus_write;
   logic [AW-1:0]    bus_addr;
   logic [W-1:0]     bus_wdata;
   logic             rsp_valid, rsp_err;
   logic [W-1:0]     rsp_rdata;
   logic             loc_valid, loc_dec;
   logic [IW-1:0]    loc_idx;
   logic [NW*IW-1:0] wait_idx;
   logic [NW*W-1:0]  wait_target;
   logic [NW-1:0]    wait_ge;
   logic             ovf_flag, unf_flag;

   sem_bank #(
      .NUM_SEM (NS),
      .WIDTH   (W),
      .ADDR_W  (AW),
      .NUM_WAIT(NW),
      .REG_WAIT(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .loc_valid(loc_valid), .loc_dec(loc_dec), .loc_idx(loc_idx),
      .wait_idx(wait_idx), .wait_target(wait_target), .wait_ge(wait_ge),
      .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   int n_vec = 0;
   int n_bad = 0;
   logic [W-1:0] model [NS];

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] at(input logic [AW-1:0] base, input int i);
      return base + AW'(i * 4);
   endfunction

   // one cycle: bus and local drive together, response visible on return
   task automatic step(input logic bv, input logic bw, input logic [AW-1:0] a,
                       input logic [W-1:0] d, input logic lv, input logic ld,
                       input logic [IW-1:0] li);
      @(negedge clk);
      bus_valid = bv; bus_write = bw; bus_addr = a; bus_wdata = d;
      loc_valid = lv; loc_dec = ld; loc_idx = li;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; loc_valid = 1'b0;
   endtask

   task automatic bwr(input logic [AW-1:0] a, input logic [W-1:0] d);
      step(1'b1, 1'b1, a, d, 1'b0, 1'b0, '0);
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
      step(1'b1, 1'b0, a, '0, 1'b0, 1'b0, '0);
      chk(req, {31'b0, rsp_valid}, 32'd1);
      chk(req, rsp_rdata, exp);
   endtask

   function automatic logic [W-1:0] pat(input int i);
      return 32'h1000_0000 + 32'(i) * 32'h0001_0101;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
      loc_valid = 1'b0; loc_dec = 1'b0; loc_idx = '0;
      wait_idx = '0; wait_target = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R1 ovf", {31'b0, ovf_flag}, 32'd0);
      chk("R1 unf", {31'b0, unf_flag}, 32'd0);
      for (int i = 0; i < NS; i++) begin
         rd_chk("R1 zero", at(A_RD, i), 32'd0);
         chk("R5 no err", {31'b0, rsp_err}, 32'd0);
      end

      // R2 set every semaphore, read back through a rotating window (R4)
      for (int i = 0; i < NS; i++) begin
         model[i] = pat(i);
         bwr(at(A_SET, i), model[i]);
         chk("R4 write rdata zero", rsp_rdata, 32'd0);
      end
      for (int i = 0; i < NS; i++) begin
         logic [AW-1:0] base;
         case (i % 4)
            0: base = A_RD;
            1: base = A_SET;
            2: base = A_INC;
            default: base = A_DEC;
         endcase
         rd_chk("R2/R4 set readback", at(base, i), model[i]);
      end

      // R3 add and subtract windows, data ignored
      for (int i = 0; i < NS; i++) begin
         bwr(at(A_INC, i), 32'hDEAD_0000 ^ 32'(i));
         model[i] = model[i] + 1;
         if (i % 3 == 0) begin
            bwr(at(A_DEC, i), 32'hFFFF_FFFF);
            bwr(at(A_DEC, i), 32'h0000_0007);
            model[i] = model[i] - 2;
         end
      end
      for (int i = 0; i < NS; i++) rd_chk("R3 inc/dec", at(A_RD, i), model[i]);

      // R4 writes to the read window have no effect
      for (int i = 0; i < 16; i++) bwr(at(A_RD, i), 32'h0);
      for (int i = 0; i < 16; i++) rd_chk("R4 read window write ignored", at(A_RD, i), model[i]);

      // R5 decode errors
      begin
         logic [AW-1:0] bad [6] = '{16'h0000, 16'h0FFC, 16'h2000, 16'hFFFC, 16'h1802, 16'h1401};
         foreach (bad[j]) begin
            bwr(bad[j], 32'h5555_5555);
            chk("R5 write err", {31'b0, rsp_err}, 32'd1);
            step(1'b1, 1'b0, bad[j], '0, 1'b0, 1'b0, '0);
            chk("R5 read err", {31'b0, rsp_err}, 32'd1);
            chk("R5 read err data", rsp_rdata, 32'd0);
         end
         rd_chk("R5 no side effect", at(A_RD, 0), model[0]);
         rd_chk("R5 no side effect", at(A_RD, 1), model[1]);
      end

      // R10 different semaphores in one cycle
      step(1'b1, 1'b1, at(A_INC, 3), '0, 1'b1, 1'b1, 8'd4);
      model[3] = model[3] + 1; model[4] = model[4] - 1;
      rd_chk("R10 bus side", at(A_RD, 3), model[3]);
      rd_chk("R10 local side", at(A_RD, 4), model[4]);

      // R7 local port and merged changes
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 8'd5); model[5] = model[5] + 1;
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 8'd6); model[6] = model[6] - 1;
      step(1'b1, 1'b1, at(A_INC, 10), '0, 1'b1, 1'b0, 8'd10); model[10] = model[10] + 2;
      step(1'b1, 1'b1, at(A_DEC, 11), '0, 1'b1, 1'b1, 8'd11); model[11] = model[11] - 2;
      step(1'b1, 1'b1, at(A_INC, 12), '0, 1'b1, 1'b1, 8'd12);
      rd_chk("R7 local inc", at(A_RD, 5), model[5]);
      rd_chk("R7 local dec", at(A_RD, 6), model[6]);
      rd_chk("R7 inc+inc", at(A_RD, 10), model[10]);
      rd_chk("R7 dec+dec", at(A_RD, 11), model[11]);
      rd_chk("R7 inc+dec", at(A_RD, 12), model[12]);
      bwr(at(A_SET, 20), 32'hFFFF_FFFF);
      step(1'b1, 1'b1, at(A_INC, 20), '0, 1'b1, 1'b1, 8'd20);
      bwr(at(A_SET, 21), 32'h0);
      step(1'b1, 1'b1, at(A_DEC, 21), '0, 1'b1, 1'b0, 8'd21);
      rd_chk("R7 cancel at max", at(A_RD, 20), 32'hFFFF_FFFF);
      rd_chk("R7 cancel at zero", at(A_RD, 21), 32'h0);
      chk("R7 no ovf", {31'b0, ovf_flag}, 32'd0);
      chk("R7 no unf", {31'b0, unf_flag}, 32'd0);

      // R8 set beats a local change
      step(1'b1, 1'b1, at(A_SET, 30), 32'h1234_5678, 1'b1, 1'b0, 8'd30);
      step(1'b1, 1'b1, at(A_SET, 31), 32'h0000_0009, 1'b1, 1'b1, 8'd31);
      rd_chk("R8 set over local inc", at(A_RD, 30), 32'h1234_5678);
      rd_chk("R8 set over local dec", at(A_RD, 31), 32'h0000_0009);

      // R9 wait comparators (registered: one extra cycle)
      bwr(at(A_SET, 40), 32'd100);
      wait_idx = {8'd41, 8'd40};
      wait_target = {32'd0, 32'd100};
      repeat (2) @(negedge clk);
      chk("R9 equal", {31'b0, wait_ge[0]}, 32'd1);
      chk("R9 zero target", {31'b0, wait_ge[1]}, 32'd1);
      wait_target = {model[41] + 32'd1, 32'd101};
      repeat (2) @(negedge clk);
      chk("R9 below", {31'b0, wait_ge[0]}, 32'd0);
      chk("R9 below other", {31'b0, wait_ge[1]}, 32'd0);
      bwr(at(A_INC, 40), 32'h0);
      @(negedge clk);
      chk("R9 after arrive", {31'b0, wait_ge[0]}, 32'd1);

      // R6 saturation and sticky flags
      bwr(at(A_SET, 50), 32'hFFFF_FFFF);
      bwr(at(A_INC, 50), 32'h0);
      rd_chk("R6 clamp high", at(A_RD, 50), 32'hFFFF_FFFF);
      chk("R6 ovf set", {31'b0, ovf_flag}, 32'd1);
      chk("R6 unf clear", {31'b0, unf_flag}, 32'd0);
      bwr(at(A_SET, 51), 32'h0);
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 8'd51);
      rd_chk("R6 clamp low", at(A_RD, 51), 32'h0);
      repeat (3) @(negedge clk);
      chk("R6 unf set", {31'b0, unf_flag}, 32'd1);
      chk("R6 ovf sticky", {31'b0, ovf_flag}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule